// File: doc/BRIEF.md
# Configurable Crosspoint I/O Cell

This block is one programmable cell of a digital crosspoint switch. It selects one of four data buses with a two-bit select code, and the two raw select lines can be swapped in their roles. A single storage element can run as an edge-triggered register or as a level-sensitive transparent latch. Static configuration bits place that element in one of two positions. In the output position it holds the selector result on its way to the pad. In the input position it holds the pad input on its way into the routing fabric. A bypass bit skips the storage element altogether, so the cell becomes purely combinational.

The storage clock can come from a dedicated clock pin or from a local I/O-derived clock, and its polarity can be inverted. The register clock enable can come from a local line or a global line, and its polarity can also be inverted. The pad output has a programmable polarity. Every configuration input is static, and it is changed only while the storage clock and the enable are quiet.

Top module: `xpt_io_cell`

## Requirements
- R1: The select code {s1,s0} decodes in Gray order: 00 selects m0_i, 01 selects m1_i, 11 selects m2_i, 10 selects m3_i. Here s1 is sel_i[1] and s0 is sel_i[0] when cfg_sel_swap_i is 0.
- R2: When cfg_sel_swap_i is 1, the roles of the two raw lines are exchanged: s1 is sel_i[0] and s0 is sel_i[1].
- R3: With cfg_bypass_i at 1 in the output position (cfg_path_b_i is 0), pad_o follows the selector with no clock. In the output position, fabric_o always equals pad_i.
- R4: In register mode (cfg_latch_i is 0) in the output position, pad_o takes the selector value on the rising effective clock edge while the enable is active. pad_o does not change between edges.
- R5: With cfg_clk_inv_i at 1, the register captures on the falling edge of the selected clock source, and a rising source edge has no effect.
- R6: cfg_clk_src_i at 0 clocks the storage from clk_ded_i, and at 1 from clk_loc_i. Edges on the clock that is not selected have no effect.
- R7: The register enable is en_loc_i when cfg_en_src_i is 0 and en_glb_i when it is 1, inverted when cfg_en_inv_i is 1. An inactive enable holds the stored value across clock edges.
- R8: In latch mode (cfg_latch_i is 1), the storage is transparent while the effective clock is high. That means the source is high, or the source is low when cfg_clk_inv_i is 1. The latch holds while the effective clock is low, and the enable has no effect on it.
- R9: In the input position (cfg_path_b_i is 1), the storage takes pad_i and drives fabric_o, and pad_o is the selector output without clocking. With cfg_bypass_i at 1 in this position, fabric_o follows pad_i.
- R10: cfg_out_inv_i at 1 inverts pad_o bitwise in every mode and leaves fabric_o unchanged.
- R11: rst_ni low asynchronously clears the storage element to 0 in both register and latch modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Active-low asynchronous clear of the storage element |
| clk_ded_i | input | 1 | Dedicated clock source |
| clk_loc_i | input | 1 | Local I/O-derived clock source |
| en_loc_i | input | 1 | Local I/O-derived clock enable |
| en_glb_i | input | 1 | Global clock enable |
| sel_i | input | 2 | Raw select lines |
| m0_i | input | DATA_W | Data input for code 00 |
| m1_i | input | DATA_W | Data input for code 01 |
| m2_i | input | DATA_W | Data input for code 11 |
| m3_i | input | DATA_W | Data input for code 10 |
| pad_i | input | DATA_W | Input from the pad |
| cfg_sel_swap_i | input | 1 | Exchange roles of the two raw select lines |
| cfg_bypass_i | input | 1 | Skip the storage element (combinational mode) |
| cfg_path_b_i | input | 1 | 0: storage in output position, 1: in input position |
| cfg_latch_i | input | 1 | 0: register, 1: transparent latch |
| cfg_clk_src_i | input | 1 | 0: clk_ded_i, 1: clk_loc_i |
| cfg_clk_inv_i | input | 1 | Invert the storage clock |
| cfg_en_src_i | input | 1 | 0: en_loc_i, 1: en_glb_i |
| cfg_en_inv_i | input | 1 | Invert the clock enable |
| cfg_out_inv_i | input | 1 | Invert pad_o |
| pad_o | output | DATA_W | Value driven toward the pad |
| fabric_o | output | DATA_W | Value driven into the routing fabric |

## Verification
The clocked checks use the effective storage clock. They assume that the data, select, enable and configuration inputs never move at the same instant as an effective clock edge. The output-path check also tolerates a change of mode or position between two edges only by skipping that pair. The stimulus moves one input at a time and separates each change from the clock toggles by a delay. It also drops the enable before it touches the clock source or polarity bits, because those changes can create a real edge on the effective clock. Reset is applied only while no clock toggles, so in-flight checks are aborted cleanly.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
  localparam int unsigned N_IN  = 4;
  localparam int unsigned SEL_W = $clog2(N_IN);

  typedef enum logic [SEL_W-1:0] {
    CODE_M0 = 2'b00,
    CODE_M1 = 2'b01,
    CODE_M2 = 2'b11,
    CODE_M3 = 2'b10
  } xpt_code_e;

  // Gray code -> input index
  function automatic logic [SEL_W-1:0] code_to_idx(input logic [SEL_W-1:0] c);
    return {c[1], c[1] ^ c[0]};
  endfunction
endpackage

// File: rtl/xpt_sel_mux.sv
module xpt_sel_mux
  import xpt_pkg::*;
#(
  parameter int unsigned DATA_W = 4
) (
  input  logic [N_IN-1:0][DATA_W-1:0] m_i,
  input  logic [SEL_W-1:0]            sel_i,
  input  logic                        swap_i,
  output logic [DATA_W-1:0]           y_o
);
  logic [SEL_W-1:0] code;
  logic [SEL_W-1:0] idx;

  assign code = swap_i ? {sel_i[0], sel_i[1]} : sel_i;
  assign idx  = code_to_idx(code);

  always_comb begin
    y_o = m_i[0];
    for (int i = 0; i < N_IN; i++) begin
      if (idx == SEL_W'(i)) y_o = m_i[i];
    end
  end
endmodule

// File: rtl/xpt_ctl.sv
module xpt_ctl (
  input  logic clk_ded_i,
  input  logic clk_loc_i,
  input  logic en_loc_i,
  input  logic en_glb_i,
  input  logic cfg_clk_src_i,
  input  logic cfg_clk_inv_i,
  input  logic cfg_en_src_i,
  input  logic cfg_en_inv_i,
  output logic clk_e_o,
  output logic en_e_o
);
  logic clk_src, en_src;

  assign clk_src = cfg_clk_src_i ? clk_loc_i : clk_ded_i;
  assign clk_e_o = clk_src ^ cfg_clk_inv_i;
  assign en_src  = cfg_en_src_i ? en_glb_i : en_loc_i;
  assign en_e_o  = en_src ^ cfg_en_inv_i;
endmodule

// File: rtl/xpt_store.sv
module xpt_store #(
  parameter int unsigned DATA_W = 4
) (
  input  logic              rst_ni,
  input  logic              clk_e_i,
  input  logic              en_i,
  input  logic              latch_i,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  logic [DATA_W-1:0] reg_q;
  logic [DATA_W-1:0] lat_q;

  always_ff @(posedge clk_e_i or negedge rst_ni) begin
    if (!rst_ni)   reg_q <= '0;
    else if (en_i) reg_q <= d_i;
  end

  // transparent while effective clock is high
  always_latch begin
    if (!rst_ni)      lat_q <= '0;
    else if (clk_e_i) lat_q <= d_i;
  end

  assign q_o = latch_i ? lat_q : reg_q;

  assert_reg_hold_R7: assert property (@(posedge clk_e_i) disable iff (!rst_ni)
    !en_i |=> $stable(reg_q));

  assert_reg_capture_R4: assert property (@(posedge clk_e_i) disable iff (!rst_ni)
    en_i |=> reg_q == $past(d_i));

  // latch must not move between closing and reopening
  logic [DATA_W-1:0] lat_snap;
  logic              lat_snap_vld;
  always_ff @(negedge clk_e_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_snap     <= '0;
      lat_snap_vld <= 1'b0;
    end else begin
      lat_snap     <= lat_q;
      lat_snap_vld <= 1'b1;
    end
  end

  assert_latch_closed_R8: assert property (@(posedge clk_e_i) disable iff (!rst_ni)
    lat_snap_vld |-> lat_q == lat_snap);
endmodule

// File: rtl/xpt_io_cell.sv
module xpt_io_cell
  import xpt_pkg::*;
#(
  parameter int unsigned DATA_W = 4
) (
  input  logic              rst_ni,
  input  logic              clk_ded_i,
  input  logic              clk_loc_i,
  input  logic              en_loc_i,
  input  logic              en_glb_i,
  input  logic [1:0]        sel_i,
  input  logic [DATA_W-1:0] m0_i,
  input  logic [DATA_W-1:0] m1_i,
  input  logic [DATA_W-1:0] m2_i,
  input  logic [DATA_W-1:0] m3_i,
  input  logic [DATA_W-1:0] pad_i,
  input  logic              cfg_sel_swap_i,
  input  logic              cfg_bypass_i,
  input  logic              cfg_path_b_i,
  input  logic              cfg_latch_i,
  input  logic              cfg_clk_src_i,
  input  logic              cfg_clk_inv_i,
  input  logic              cfg_en_src_i,
  input  logic              cfg_en_inv_i,
  input  logic              cfg_out_inv_i,
  output logic [DATA_W-1:0] pad_o,
  output logic [DATA_W-1:0] fabric_o
);
  logic [N_IN-1:0][DATA_W-1:0] m_bus;
  logic [DATA_W-1:0] mux_y, store_d, store_q, pad_pre;
  logic clk_e, en_e;

  assign m_bus = {m3_i, m2_i, m1_i, m0_i};

  xpt_sel_mux #(.DATA_W(DATA_W)) u_mux (
    .m_i   (m_bus),
    .sel_i (sel_i),
    .swap_i(cfg_sel_swap_i),
    .y_o   (mux_y)
  );

  xpt_ctl u_ctl (
    .clk_ded_i    (clk_ded_i),
    .clk_loc_i    (clk_loc_i),
    .en_loc_i     (en_loc_i),
    .en_glb_i     (en_glb_i),
    .cfg_clk_src_i(cfg_clk_src_i),
    .cfg_clk_inv_i(cfg_clk_inv_i),
    .cfg_en_src_i (cfg_en_src_i),
    .cfg_en_inv_i (cfg_en_inv_i),
    .clk_e_o      (clk_e),
    .en_e_o       (en_e)
  );

  assign store_d = cfg_path_b_i ? pad_i : mux_y;

  xpt_store #(.DATA_W(DATA_W)) u_store (
    .rst_ni (rst_ni),
    .clk_e_i(clk_e),
    .en_i   (en_e),
    .latch_i(cfg_latch_i),
    .d_i    (store_d),
    .q_o    (store_q)
  );

  always_comb begin
    if (cfg_path_b_i) begin
      pad_pre  = mux_y;
      fabric_o = cfg_bypass_i ? pad_i : store_q;
    end else begin
      pad_pre  = cfg_bypass_i ? mux_y : store_q;
      fabric_o = pad_i;
    end
  end

  assign pad_o = pad_pre ^ {DATA_W{cfg_out_inv_i}};

  // end-to-end: registered value reaches the proper port one edge later
  assert_path_reg_R9: assert property (@(posedge clk_e) disable iff (!rst_ni)
    (!cfg_bypass_i && !cfg_latch_i && en_e) |=>
      (!$stable({cfg_bypass_i, cfg_latch_i, cfg_path_b_i}) || cfg_bypass_i || cfg_latch_i ||
       (cfg_path_b_i ? (fabric_o == $past(pad_i))
                     : (pad_o == ($past(mux_y) ^ {DATA_W{cfg_out_inv_i}})))));
endmodule

// File: tb/xpt_io_cell_test.sv
`timescale 1ns/1ps
module xpt_io_cell_test;
  localparam int unsigned W = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_ni, clk_ded, clk_loc, en_loc, en_glb;
  logic [1:0] sel;
  logic [W-1:0] m0, m1, m2, m3, pad_in, pad_out, fab_out;
  logic c_swap, c_byp, c_pb, c_lat, c_csrc, c_cinv, c_esrc, c_einv, c_oinv;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  xpt_io_cell #(.DATA_W(W)) uut (
    .rst_ni(rst_ni), .clk_ded_i(clk_ded), .clk_loc_i(clk_loc),
    .en_loc_i(en_loc), .en_glb_i(en_glb), .sel_i(sel),
    .m0_i(m0), .m1_i(m1), .m2_i(m2), .m3_i(m3), .pad_i(pad_in),
    .cfg_sel_swap_i(c_swap), .cfg_bypass_i(c_byp), .cfg_path_b_i(c_pb),
    .cfg_latch_i(c_lat), .cfg_clk_src_i(c_csrc), .cfg_clk_inv_i(c_cinv),
    .cfg_en_src_i(c_esrc), .cfg_en_inv_i(c_einv), .cfg_out_inv_i(c_oinv),
    .pad_o(pad_out), .fabric_o(fab_out)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic pulse_ded();
    clk_ded = 1'b1; #2; clk_ded = 1'b0; #2;
  endtask

  task automatic pulse_loc();
    clk_loc = 1'b1; #2; clk_loc = 1'b0; #2;
  endtask

  task automatic t_reset_state();
    settle();
    chk("R11 reset pad", pad_out, 4'h0);
    chk("R3 fabric=pad_i", fab_out, 4'h0);
    pad_in = 4'h6; settle();
    chk("R3 fabric follows pad_i", fab_out, 4'h6);
    rst_ni = 1'b1; settle();
  endtask

  task automatic t_gray();
    c_byp = 1'b1;
    sel = 2'b00; settle(); chk("R1 code00", pad_out, 4'h1);
    sel = 2'b01; settle(); chk("R1 code01", pad_out, 4'h2);
    sel = 2'b11; settle(); chk("R1 code11", pad_out, 4'h4);
    sel = 2'b10; settle(); chk("R1 code10", pad_out, 4'h8);
  endtask

  task automatic t_swap();
    c_swap = 1'b1;
    sel = 2'b01; settle(); chk("R2 swapped 01", pad_out, 4'h8);
    sel = 2'b10; settle(); chk("R2 swapped 10", pad_out, 4'h2);
    c_swap = 1'b0; settle();
    chk("R3 bypass comb", pad_out, 4'h8);
  endtask

  task automatic t_reg();
    c_byp = 1'b0; en_loc = 1'b1; sel = 2'b00; settle();
    chk("R4 before edge", pad_out, 4'h0);
    pulse_ded(); chk("R4 captured", pad_out, 4'h1);
    sel = 2'b11; settle(); chk("R4 holds between edges", pad_out, 4'h1);
    pulse_ded(); chk("R4 second capture", pad_out, 4'h4);
  endtask

  task automatic t_clk_inv();
    en_loc = 1'b0; settle();
    c_cinv = 1'b1; settle();
    sel = 2'b01; settle();
    en_loc = 1'b1; settle();
    clk_ded = 1'b1; #2; chk("R5 rising ignored", pad_out, 4'h4);
    clk_ded = 1'b0; #2; chk("R5 falling captures", pad_out, 4'h2);
    en_loc = 1'b0; settle();
    c_cinv = 1'b0; settle();
  endtask

  task automatic t_clk_src();
    c_csrc = 1'b1; settle();
    en_loc = 1'b1; sel = 2'b10; settle();
    pulse_ded(); chk("R6 dedicated ignored", pad_out, 4'h2);
    pulse_loc(); chk("R6 local clocks", pad_out, 4'h8);
    en_loc = 1'b0; settle();
    c_csrc = 1'b0; settle();
  endtask

  task automatic t_enable();
    sel = 2'b00; settle();
    pulse_ded(); chk("R7 local enable low holds", pad_out, 4'h8);
    c_esrc = 1'b1; en_glb = 1'b1; settle();
    pulse_ded(); chk("R7 global enable", pad_out, 4'h1);
    sel = 2'b01; c_einv = 1'b1; settle();
    pulse_ded(); chk("R7 inverted enable holds", pad_out, 4'h1);
    en_glb = 1'b0; settle();
    pulse_ded(); chk("R7 inverted enable active", pad_out, 4'h2);
    c_einv = 1'b0; settle();
    c_esrc = 1'b0; settle();
  endtask

  task automatic t_latch();
    c_lat = 1'b1; sel = 2'b11; settle();
    clk_ded = 1'b1; settle(); chk("R8 open", pad_out, 4'h4);
    sel = 2'b10; settle(); chk("R8 transparent", pad_out, 4'h8);
    clk_ded = 1'b0; settle();
    sel = 2'b00; settle(); chk("R8 closed holds", pad_out, 4'h8);
    c_cinv = 1'b1; settle(); chk("R8 low-level open", pad_out, 4'h1);
    clk_ded = 1'b1; settle();
    sel = 2'b01; settle(); chk("R8 inverted closed holds", pad_out, 4'h1);
    clk_ded = 1'b0; settle();
    c_cinv = 1'b0; settle();
    c_lat = 1'b0; settle();
  endtask

  task automatic t_path_b();
    c_pb = 1'b1; en_loc = 1'b1; pad_in = 4'h5; settle();
    chk("R9 fabric shows stored", fab_out, 4'h2);
    sel = 2'b11; settle(); chk("R9 pad is mux", pad_out, 4'h4);
    pulse_ded(); chk("R9 captures pad_i", fab_out, 4'h5);
    pad_in = 4'h9; settle(); chk("R9 holds", fab_out, 4'h5);
    pulse_ded(); chk("R9 recapture", fab_out, 4'h9);
    c_byp = 1'b1; settle(); chk("R9 bypass", fab_out, 4'h9);
    pad_in = 4'h3; settle(); chk("R9 bypass follows", fab_out, 4'h3);
    c_byp = 1'b0; settle(); chk("R9 stored again", fab_out, 4'h9);
    en_loc = 1'b0; c_pb = 1'b0; settle();
  endtask

  task automatic t_out_inv();
    c_oinv = 1'b1; c_byp = 1'b1; sel = 2'b00; settle();
    chk("R10 bypass inverted", pad_out, 4'hE);
    c_byp = 1'b0; settle(); chk("R10 stored inverted", pad_out, 4'h6);
    c_pb = 1'b1; sel = 2'b01; settle();
    chk("R10 path B pad inverted", pad_out, 4'hD);
    chk("R10 fabric not inverted", fab_out, 4'h9);
    c_pb = 1'b0; c_oinv = 1'b0; settle();
  endtask

  task automatic t_reset_again();
    c_oinv = 1'b1; rst_ni = 1'b0; settle();
    chk("R11 cleared register", pad_out, 4'hF);
    c_oinv = 1'b0; settle();
    c_lat = 1'b1; settle(); chk("R11 cleared latch", pad_out, 4'h0);
    rst_ni = 1'b1; settle();
    c_lat = 1'b0; settle();
    chk("R3 fabric path A", fab_out, 4'h3);
  endtask

  initial begin
    rst_ni = 1'b0; clk_ded = 1'b0; clk_loc = 1'b0; en_loc = 1'b0; en_glb = 1'b0;
    sel = 2'b00; m0 = 4'h1; m1 = 4'h2; m2 = 4'h4; m3 = 4'h8; pad_in = 4'h0;
    c_swap = 1'b0; c_byp = 1'b0; c_pb = 1'b0; c_lat = 1'b0; c_csrc = 1'b0;
    c_cinv = 1'b0; c_esrc = 1'b0; c_einv = 1'b0; c_oinv = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_gray();
    t_swap();
    t_reg();
    t_clk_inv();
    t_clk_src();
    t_enable();
    t_latch();
    t_path_b();
    t_out_inv();
    t_reset_again();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule